// File: doc/BRIEF.md
# PDM Dual-Edge Microphone Capture Router

This block is the front end of a four-channel PDM microphone receiver. It always acts as the clock master. It divides the system clock to make the microphone bit clock with a 50% duty cycle. Two PDM data lines come in, and each line is shared by two microphones. One microphone drives its bit before the rising clock edge and the other drives its bit before the falling edge. The block therefore has four microphone slots. It samples each line at the system-clock edge on which the bit clock rises, and again at the edge on which it falls.

Each of the four logical output channels picks its own slot. A line-select bit chooses the data line and an edge-select bit chooses which half-cycle sample to use. Any slot can feed any channel, and several channels may read the same slot. All enabled channels present their bits together with one valid strobe per bit period, and this output feeds the decimation filters downstream. Clearing every enable stops the bit clock, for example on stop or pause. Setting an enable again restarts the clock from a fresh low phase.

Top module: `pdm_edge_router`

## Requirements
- R1: While any channel is enabled, `pdm_clk` stays low for exactly `half_div`+1 system cycles and high for exactly `half_div`+1 system cycles, so the divisor is 2×(`half_div`+1).
- R2: While no channel is enabled, `pdm_clk` is held low and no `ch_valid` bit is asserted. This applies even when the enables are cleared during the high phase.
- R3: Each data line is captured at the system-clock edge on which `pdm_clk` rises (the rising sample) and at the edge on which it falls (the falling sample).
- R4: Exactly one strobe is produced per bit period. It lasts one system cycle and appears in the cycle that follows the fall of `pdm_clk`, asserted on `ch_valid[i]` of every enabled channel.
- R5: `line_sel[i]`=0 routes channel i from `pdm_din[0]`, and `line_sel[i]`=1 routes it from `pdm_din[1]`.
- R6: `edge_sel[i]`=0 gives channel i the rising sample of its line, and `edge_sel[i]`=1 gives it the falling sample.
- R7: A disabled channel drives `ch_bit[i]`=0 and `ch_valid[i]`=0 while the other channels run.
- R8: After reset, `pdm_clk`, `ch_bit` and `ch_valid` are all zero.
- R9: When a channel is enabled from the stopped state, the first rise of `pdm_clk` occurs after a full low phase of `half_div`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_div | input | DIV_W | Half bit-clock period minus one, in system cycles |
| ch_en | input | NUM_CH | Per-channel enable |
| line_sel | input | NUM_CH | Per-channel data line choice |
| edge_sel | input | NUM_CH | Per-channel clock edge choice |
| pdm_din | input | 2 | The two shared PDM data lines |
| pdm_clk | output | 1 | Microphone bit clock |
| ch_bit | output | NUM_CH | Routed PDM bit per channel |
| ch_valid | output | NUM_CH | Per-channel valid strobe, one per bit period |

## Verification
The bench keeps the defaults of four channels and an 8-bit divider, and it steps `half_div` through 0, 1, 2 and 5. The value 0 gives one-cycle half periods, so the strobe and the next rising capture fall on adjacent cycles. The larger values allow the bench to measure phase lengths and to confirm that data driven only inside a half period is the value captured. The bench also uses routing patterns where every channel reads the same slot, patterns that invert the natural map, and a partial enable. Together these expose any crossing of the line and edge selects.

// File: rtl/pdm_edge_router.sv
module pdm_edge_router #(
  parameter int NUM_CH = 4,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] line_sel,
  input  logic [NUM_CH-1:0] edge_sel,
  input  logic [1:0]        pdm_din,
  output logic              pdm_clk,
  output logic [NUM_CH-1:0] ch_bit,
  output logic [NUM_CH-1:0] ch_valid
);

  logic [DIV_W-1:0] cnt;
  logic             clk_q;
  logic             strobe_q;
  logic [1:0]       rise_smp;
  logic [1:0]       fall_smp;

  wire run  = |ch_en;
  wire tick = run && (cnt == half_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      clk_q    <= 1'b0;
      strobe_q <= 1'b0;
      rise_smp <= '0;
      fall_smp <= '0;
    end else begin
      strobe_q <= tick && clk_q;
      if (!run) begin
        cnt   <= '0;
        clk_q <= 1'b0;
      end else if (tick) begin
        cnt   <= '0;
        clk_q <= ~clk_q;
        if (clk_q) fall_smp <= pdm_din;
        else       rise_smp <= pdm_din;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pdm_clk = clk_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_route
    wire slot = edge_sel[i] ? fall_smp[line_sel[i]] : rise_smp[line_sel[i]];
    assign ch_bit[i]   = ch_en[i] & slot;
    assign ch_valid[i] = ch_en[i] & strobe_q;
  end

  a_r1_stable_mid_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0) |-> $stable(clk_q));

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!clk_q && cnt == '0));

  a_r4_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $fell(clk_q));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  a_r3_fall_capture: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (fall_smp == $past(pdm_din)));

endmodule

// File: tb/pdm_edge_router_bench.sv
module pdm_edge_router_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_div = '0;
  logic [3:0] ch_en = '0, line_sel = '0, edge_sel = '0;
  logic [1:0] pdm_din = '0;
  logic       pdm_clk;
  logic [3:0] ch_bit, ch_valid;

  int checks = 0;
  int errors = 0;
  logic [15:0] lf = 16'hACE1;
  logic [1:0]  drv_low, drv_high;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_edge_router u_pdm_edge_router (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .ch_en(ch_en),
    .line_sel(line_sel), .edge_sel(edge_sel), .pdm_din(pdm_din),
    .pdm_clk(pdm_clk), .ch_bit(ch_bit), .ch_valid(ch_valid));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] next_bits();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[1:0];
  endfunction

  task automatic stop_all();
    @(negedge clk);
    ch_en = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(pdm_clk == 1'b0, "R8 pdm_clk", pdm_clk, 0);
    check(ch_valid == '0, "R8 ch_valid", ch_valid, 0);
    check(ch_bit == '0, "R8 ch_bit", ch_bit, 0);
  endtask

  task automatic t_route(input logic [3:0] en, input logic [3:0] ln, input logic [3:0] ed,
                         input logic [7:0] hd, input int frames);
    logic last;
    int falls = 0;
    int strobes = 0;
    stop_all();
    drv_low = next_bits();
    pdm_din = drv_low;
    half_div = hd; line_sel = ln; edge_sel = ed; ch_en = en;
    last = 1'b0;
    while (falls < frames) begin
      @(negedge clk);
      if (pdm_clk != last && !pdm_clk) begin
        strobes++;
        for (int i = 0; i < 4; i++) begin
          if (en[i]) begin
            logic e;
            e = ed[i] ? drv_high[ln[i]] : drv_low[ln[i]];
            check(ch_valid[i] == 1'b1, "R4 strobe", ch_valid[i], 1);
            check(ch_bit[i] == e, ed[i] ? "R6/R5 falling slot" : "R5/R6 rising slot", ch_bit[i], e);
          end else begin
            check(ch_valid[i] == 1'b0 && ch_bit[i] == 1'b0, "R7 disabled channel",
                  {ch_valid[i], ch_bit[i]}, 0);
          end
        end
      end else if (ch_valid != '0) begin
        check(1'b0, "R4 stray strobe", ch_valid, 0);
      end
      if (pdm_clk != last) begin
        if (pdm_clk) begin drv_high = next_bits(); pdm_din = drv_high; end
        else begin drv_low = next_bits(); pdm_din = drv_low; falls++; end
      end
      last = pdm_clk;
    end
    check(strobes == frames, "R4 strobe count", strobes, frames);
  endtask

  task automatic t_period(input logic [7:0] hd);
    int n;
    stop_all();
    check(pdm_clk == 1'b0 && ch_valid == '0, "R2 stopped", pdm_clk, 0);
    half_div = hd;
    ch_en = 4'b0001;
    n = 0;
    do begin @(negedge clk); n++; end while (pdm_clk == 1'b0 && n < 600);
    check(n == hd + 1, "R9 first rise", n, hd + 1);
    n = 0;
    while (pdm_clk == 1'b1 && n < 600) begin @(negedge clk); n++; end
    check(n == hd + 1, "R1 high phase", n, hd + 1);
    n = 0;
    while (pdm_clk == 1'b0 && n < 600) begin @(negedge clk); n++; end
    check(n == hd + 1, "R1 low phase", n, hd + 1);
  endtask

  task automatic t_stop_high();
    int bad = 0;
    stop_all();
    half_div = 8'd3;
    ch_en = 4'b1111;
    do @(negedge clk); while (pdm_clk == 1'b0);
    ch_en = '0;
    repeat (12) begin
      @(negedge clk);
      if (pdm_clk || ch_valid != '0) bad++;
    end
    check(bad == 0, "R2 stop during high phase", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(8'd0);
    t_period(8'd2);
    t_period(8'd5);
    t_route(4'b1111, 4'b1100, 4'b1010, 8'd2, 20);
    t_route(4'b1111, 4'b0011, 4'b0101, 8'd0, 20);
    t_route(4'b1111, 4'b1111, 4'b1111, 8'd5, 10);
    t_route(4'b0101, 4'b1010, 4'b0110, 8'd1, 20);
    t_stop_high();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule